// File: doc/BRIEF.md
# Sum-of-Products Logic Block

This block is one logic slice of a programmable sum-of-products fabric. A 36-bit input word is widened into 72 literals, each input appearing once as itself and once inverted. A static configuration image defines 87 AND terms over those literals. Eighty of them form a general pool that an allocator steers and shares among 16 macrocell sums. The remaining seven are control terms: four output enables, a block-wide set, a block-wide reset and a block-wide term clock. Each control term has its own programmable inversion, so an OR of inverted literals can be built in one pass.

The configuration arrives on wide parallel ports that are held static while the block is in use. Every output is a combinational function of the input word and the configuration. Two per-macrocell flags report steering masks that break the allocation rules. The registers that follow the sums, the global routing and the programming path are not part of this block.

Top module: `pt_logic_block`

## Requirements
- R1: Literal k of the 72-literal field is `in_bits[k]` for k below 36 and `~in_bits[k-36]` for k from 36 upward; term j is the AND of every literal k whose enable bit `cfg_lit_en[j*72+k]` is set.
- R2: A term whose literal-enable mask is empty evaluates to 1; a term whose bit in `cfg_term_off` is set evaluates to 0 whatever its mask holds.
- R3: `mc_sum[m]` is the OR of the general terms (indices 0 to 79) selected by bits `cfg_sel[m*80 +: 80]` that belong to its sharing group; a macrocell with an all-zero mask produces 0.
- R4: Macrocells m and 4*(m/4)+0..3 form one sharing group that owns general terms 20*(m/4) to 20*(m/4)+19; one term selected by several macrocells of its group feeds each of their sums.
- R5: A mask bit that selects a general term owned by another group has no effect on `mc_sum[m]` and raises `err_share[m]`.
- R6: `err_steer[m]` is 1 exactly when more than 16 bits of the macrocell's mask are set; a mask with 16 or fewer bits leaves it 0, and the sum is still formed from the in-group bits.
- R7: Terms 80 and 81 are the output-enable pair for macrocells 0 to 7, terms 82 and 83 the pair for macrocells 8 to 15; `cfg_oe_pick[m]` = 0 picks the lower index of the pair, 1 the higher; `mc_oe[m]` is that term XOR `cfg_oe_inv[term-80]`.
- R8: `blk_set`, `blk_rst` and `blk_clk` equal terms 84, 85 and 86 XOR `cfg_set_inv`, `cfg_rst_inv` and `cfg_clk_inv` respectively.
- R9: No output depends on a clock: a change on `in_bits` or the configuration reaches every output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_bits | input | 36 | Input word routed into the slice |
| cfg_lit_en | input | 6264 | Literal-enable masks, 72 bits per term, term 0 lowest |
| cfg_term_off | input | 87 | Per-term disable, forces the term to 0 |
| cfg_sel | input | 1280 | Steering masks, 80 bits per macrocell, macrocell 0 lowest |
| cfg_oe_pick | input | 16 | Per-macrocell choice within its output-enable pair |
| cfg_oe_inv | input | 4 | Inversion of each output-enable term |
| cfg_set_inv | input | 1 | Inversion of the set term |
| cfg_rst_inv | input | 1 | Inversion of the reset term |
| cfg_clk_inv | input | 1 | Inversion of the clock term |
| mc_sum | output | 16 | Sum of products per macrocell |
| mc_oe | output | 16 | Output enable per macrocell |
| blk_set | output | 1 | Block-wide set term after inversion |
| blk_rst | output | 1 | Block-wide reset term after inversion |
| blk_clk | output | 1 | Block-wide clock term after inversion |
| err_steer | output | 16 | Mask holds more than 16 terms |
| err_share | output | 16 | Mask selects a term owned by another group |

## Verification
With no state inside, a wrong term evaluation, ownership decode or pair selection shows on the affected sum, enable or control output at once, with no latency to wait for. The stimulus therefore targets the places where a fault hides behind an OR: single-term sums where a flipped literal polarity inverts the result, terms shared between macrocells of one group, foreign-group bits that must be silently dropped, and steering counts of exactly 16 and 17. Inputs change away from any clock edge before sampling, so a hidden register would return stale values.

// File: rtl/pt_pkg.sv
package pt_pkg;
    // Default geometry of one slice
    localparam int IN_W      = 36;
    localparam int MC_N      = 16;
    localparam int GEN_N     = 80;
    localparam int GRP_SZ    = 4;
    localparam int STEER_MAX = 16;
    // Control-term layout after the general pool
    localparam int OE_N      = 4;
    localparam int CTRL_N    = OE_N + 3;

    typedef struct packed {
        logic set;
        logic rst;
        logic clk;
    } blk_ctl_t;

    // First general term owned by the group holding macrocell mc
    function automatic int grp_first_term(int mc, int grp_sz, int per_grp);
        return (mc / grp_sz) * per_grp;
    endfunction
endpackage

// File: rtl/pt_term_array.sv
module pt_term_array #(
    parameter int N_IN   = 36,
    parameter int N_TERM = 87
) (
    input  logic [N_IN-1:0]            in_bits,
    input  logic [N_TERM*2*N_IN-1:0]   lit_en,
    input  logic [N_TERM-1:0]          term_off,
    output logic [N_TERM-1:0]          terms
);
    localparam int N_LIT = 2 * N_IN;

    logic [N_LIT-1:0] lits;

    assign lits = {~in_bits, in_bits};

    // Each term: every enabled literal must be high; no enabled literal gives 1
    always_comb begin
        for (int j = 0; j < N_TERM; j++) begin
            terms[j] = ~term_off[j] & (&(lits | ~lit_en[j*N_LIT +: N_LIT]));
        end
    end
endmodule

// File: rtl/pt_allocator.sv
module pt_allocator #(
    parameter int N_MC      = 16,
    parameter int N_GEN     = 80,
    parameter int GRP_SZ    = 4,
    parameter int STEER_MAX = 16
) (
    input  logic [N_GEN-1:0]        gen_terms,
    input  logic [N_MC*N_GEN-1:0]   sel,
    output logic [N_MC-1:0]         sum,
    output logic [N_MC-1:0]         err_steer,
    output logic [N_MC-1:0]         err_share
);
    localparam int N_GRP   = N_MC / GRP_SZ;
    localparam int PER_GRP = N_GEN / N_GRP;
    localparam int CNT_W   = $clog2(N_GEN + 1);

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        localparam int GRP = m / GRP_SZ;

        logic [N_GEN-1:0] own;
        logic [N_GEN-1:0] mask;
        logic [CNT_W-1:0] cnt;

        assign mask = sel[m*N_GEN +: N_GEN];

        always_comb begin
            for (int t = 0; t < N_GEN; t++) begin
                own[t] = ((t / PER_GRP) == GRP);
            end
        end

        always_comb begin
            cnt = '0;
            for (int t = 0; t < N_GEN; t++) begin
                cnt = cnt + CNT_W'(mask[t]);
            end
        end

        assign sum[m]       = |(mask & own & gen_terms);
        assign err_share[m] = |(mask & ~own);
        assign err_steer[m] = (cnt > CNT_W'(STEER_MAX));
    end
endmodule

// File: rtl/pt_ctrl_terms.sv
module pt_ctrl_terms
    import pt_pkg::*;
#(
    parameter int N_MC = 16
) (
    input  logic [OE_N-1:0]  oe_terms,
    input  logic             set_term,
    input  logic             rst_term,
    input  logic             clk_term,
    input  logic [N_MC-1:0]  oe_pick,
    input  logic [OE_N-1:0]  oe_inv,
    input  logic             set_inv,
    input  logic             rst_inv,
    input  logic             clk_inv,
    output logic [N_MC-1:0]  mc_oe,
    output blk_ctl_t         ctl
);
    localparam int HALF     = N_MC / 2;
    localparam int PAIR     = OE_N / 2;

    logic [OE_N-1:0] oe_pol;

    assign oe_pol = oe_terms ^ oe_inv;

    // Each half of the macrocells sees only its own pair of enable terms
    for (genvar m = 0; m < N_MC; m++) begin : g_oe
        localparam int BASE = (m / HALF) * PAIR;
        assign mc_oe[m] = oe_pick[m] ? oe_pol[BASE+1] : oe_pol[BASE];
    end

    assign ctl.set = set_term ^ set_inv;
    assign ctl.rst = rst_term ^ rst_inv;
    assign ctl.clk = clk_term ^ clk_inv;
endmodule

// File: rtl/pt_logic_block.sv
module pt_logic_block
    import pt_pkg::*;
#(
    parameter int N_IN      = IN_W,
    parameter int N_MC      = MC_N,
    parameter int N_GEN     = GEN_N,
    parameter int GRP_SIZE  = GRP_SZ,
    parameter int MAX_STEER = STEER_MAX,
    localparam int N_LIT    = 2 * N_IN,
    localparam int N_TERM   = N_GEN + CTRL_N
) (
    input  logic [N_IN-1:0]            in_bits,
    input  logic [N_TERM*N_LIT-1:0]    cfg_lit_en,
    input  logic [N_TERM-1:0]          cfg_term_off,
    input  logic [N_MC*N_GEN-1:0]      cfg_sel,
    input  logic [N_MC-1:0]            cfg_oe_pick,
    input  logic [OE_N-1:0]            cfg_oe_inv,
    input  logic                       cfg_set_inv,
    input  logic                       cfg_rst_inv,
    input  logic                       cfg_clk_inv,
    output logic [N_MC-1:0]            mc_sum,
    output logic [N_MC-1:0]            mc_oe,
    output logic                       blk_set,
    output logic                       blk_rst,
    output logic                       blk_clk,
    output logic [N_MC-1:0]            err_steer,
    output logic [N_MC-1:0]            err_share
);
    localparam int SET_IDX = N_GEN + OE_N;
    localparam int RST_IDX = SET_IDX + 1;
    localparam int CLK_IDX = SET_IDX + 2;

    logic [N_TERM-1:0] terms;
    blk_ctl_t          ctl;

    pt_term_array #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) u_terms (
        .in_bits  (in_bits),
        .lit_en   (cfg_lit_en),
        .term_off (cfg_term_off),
        .terms    (terms)
    );

    pt_allocator #(
        .N_MC      (N_MC),
        .N_GEN     (N_GEN),
        .GRP_SZ    (GRP_SIZE),
        .STEER_MAX (MAX_STEER)
    ) u_alloc (
        .gen_terms (terms[N_GEN-1:0]),
        .sel       (cfg_sel),
        .sum       (mc_sum),
        .err_steer (err_steer),
        .err_share (err_share)
    );

    pt_ctrl_terms #(
        .N_MC (N_MC)
    ) u_ctrl (
        .oe_terms (terms[N_GEN +: OE_N]),
        .set_term (terms[SET_IDX]),
        .rst_term (terms[RST_IDX]),
        .clk_term (terms[CLK_IDX]),
        .oe_pick  (cfg_oe_pick),
        .oe_inv   (cfg_oe_inv),
        .set_inv  (cfg_set_inv),
        .rst_inv  (cfg_rst_inv),
        .clk_inv  (cfg_clk_inv),
        .mc_oe    (mc_oe),
        .ctl      (ctl)
    );

    assign blk_set = ctl.set;
    assign blk_rst = ctl.rst;
    assign blk_clk = ctl.clk;
endmodule

// File: rtl/pt_logic_block_chk.sv
module pt_logic_block_chk
    import pt_pkg::*;
#(
    parameter int N_IN      = IN_W,
    parameter int N_MC      = MC_N,
    parameter int N_GEN     = GEN_N,
    parameter int GRP_SIZE  = GRP_SZ,
    parameter int MAX_STEER = STEER_MAX,
    localparam int N_LIT    = 2 * N_IN,
    localparam int N_TERM   = N_GEN + CTRL_N
) (
    input  logic [N_IN-1:0]            in_bits,
    input  logic [N_TERM*N_LIT-1:0]    cfg_lit_en,
    input  logic [N_TERM-1:0]          cfg_term_off,
    input  logic [N_MC*N_GEN-1:0]      cfg_sel,
    input  logic [N_MC-1:0]            cfg_oe_pick,
    input  logic [OE_N-1:0]            cfg_oe_inv,
    input  logic                       cfg_set_inv,
    input  logic                       cfg_rst_inv,
    input  logic                       cfg_clk_inv,
    input  logic [N_MC-1:0]            mc_sum,
    input  logic [N_MC-1:0]            mc_oe,
    input  logic                       blk_set,
    input  logic                       blk_rst,
    input  logic                       blk_clk,
    input  logic [N_MC-1:0]            err_steer,
    input  logic [N_MC-1:0]            err_share
);
    localparam int PER_GRP = N_GEN / (N_MC / GRP_SIZE);
    localparam int SET_IDX = N_GEN + OE_N;

    function automatic logic [N_GEN-1:0] own_of(int m);
        logic [N_GEN-1:0] o;
        int lo;
        lo = grp_first_term(m, GRP_SIZE, PER_GRP);
        o = '0;
        for (int t = 0; t < N_GEN; t++) o[t] = (t >= lo) && (t < lo + PER_GRP);
        return o;
    endfunction

    // An in-group selected term that is enabled with an empty mask forces the sum high
    function automatic logic has_empty_on(int m);
        logic hit;
        logic [N_GEN-1:0] s;
        s = cfg_sel[m*N_GEN +: N_GEN] & own_of(m);
        hit = 1'b0;
        for (int t = 0; t < N_GEN; t++) begin
            if (s[t] && !cfg_term_off[t] && (cfg_lit_en[t*N_LIT +: N_LIT] == '0)) hit = 1'b1;
        end
        return hit;
    endfunction

    always_comb begin
        for (int m = 0; m < N_MC; m++) begin
            if (cfg_sel[m*N_GEN +: N_GEN] == '0) begin
                p_zero_mask_r3: assert (mc_sum[m] == 1'b0)
                    else $error("empty steering mask gave nonzero sum at %0d", m);
            end
            if ((cfg_sel[m*N_GEN +: N_GEN] != '0) &&
                ((cfg_sel[m*N_GEN +: N_GEN] & own_of(m)) == '0)) begin
                p_foreign_only_r5: assert (mc_sum[m] == 1'b0 && err_share[m])
                    else $error("foreign-only mask not dropped at %0d", m);
            end
            if ($countones(cfg_sel[m*N_GEN +: N_GEN]) <= MAX_STEER) begin
                p_steer_ok_r6: assert (!err_steer[m])
                    else $error("steering flag on legal count at %0d", m);
            end
            if (has_empty_on(m)) begin
                p_empty_term_r2: assert (mc_sum[m] == 1'b1)
                    else $error("empty-mask term did not drive sum at %0d", m);
            end
            if (cfg_term_off[N_GEN + (m / (N_MC/2)) * 2 + int'(cfg_oe_pick[m])]) begin
                p_oe_off_r7: assert (mc_oe[m] ==
                        cfg_oe_inv[(m / (N_MC/2)) * 2 + int'(cfg_oe_pick[m])])
                    else $error("disabled enable term not at polarity level at %0d", m);
            end
        end
        if (cfg_term_off[SET_IDX]) begin
            p_set_off_r8: assert (blk_set == cfg_set_inv) else $error("set level");
        end
        if (cfg_term_off[SET_IDX+1]) begin
            p_rst_off_r8: assert (blk_rst == cfg_rst_inv) else $error("reset level");
        end
        if (cfg_term_off[SET_IDX+2]) begin
            p_clk_off_r8: assert (blk_clk == cfg_clk_inv) else $error("clock level");
        end
    end
endmodule

bind pt_logic_block pt_logic_block_chk #(
    .N_IN      (N_IN),
    .N_MC      (N_MC),
    .N_GEN     (N_GEN),
    .GRP_SIZE  (GRP_SIZE),
    .MAX_STEER (MAX_STEER)
) u_chk (.*);

// File: tb/sim_pt_logic_block.sv
module sim_pt_logic_block;
    localparam int NI = 36;
    localparam int NL = 72;
    localparam int NM = 16;
    localparam int NG = 80;
    localparam int NT = 87;

    typedef struct {
        string      req;
        int         field;
        logic [15:0] exp;
    } item_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [NI-1:0]     in_bits;
    logic [NT*NL-1:0]  cfg_lit_en;
    logic [NT-1:0]     cfg_term_off;
    logic [NM*NG-1:0]  cfg_sel;
    logic [NM-1:0]     cfg_oe_pick;
    logic [3:0]        cfg_oe_inv;
    logic              cfg_set_inv, cfg_rst_inv, cfg_clk_inv;
    logic [NM-1:0]     mc_sum, mc_oe, err_steer, err_share;
    logic              blk_set, blk_rst, blk_clk;

    pt_logic_block u0 (
        .in_bits(in_bits), .cfg_lit_en(cfg_lit_en), .cfg_term_off(cfg_term_off),
        .cfg_sel(cfg_sel), .cfg_oe_pick(cfg_oe_pick), .cfg_oe_inv(cfg_oe_inv),
        .cfg_set_inv(cfg_set_inv), .cfg_rst_inv(cfg_rst_inv), .cfg_clk_inv(cfg_clk_inv),
        .mc_sum(mc_sum), .mc_oe(mc_oe), .blk_set(blk_set), .blk_rst(blk_rst),
        .blk_clk(blk_clk), .err_steer(err_steer), .err_share(err_share)
    );

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model written from the requirements
    function automatic bit m_term(int j);
        if (cfg_term_off[j]) return 1'b0;
        for (int k = 0; k < NL; k++) begin
            if (cfg_lit_en[j*NL+k]) begin
                if (k < NI) begin
                    if (!in_bits[k]) return 1'b0;
                end else begin
                    if (in_bits[k-NI]) return 1'b0;
                end
            end
        end
        return 1'b1;
    endfunction

    function automatic logic [15:0] m_field(int f);
        logic [15:0] r;
        r = '0;
        for (int m = 0; m < NM; m++) begin
            int cnt;
            int g;
            cnt = 0;
            g = m / 4;
            for (int t = 0; t < NG; t++) begin
                if (cfg_sel[m*NG+t]) begin
                    cnt++;
                    if (t / 20 == g) begin
                        if (f == 0 && m_term(t)) r[m] = 1'b1;
                    end else if (f == 4) r[m] = 1'b1;
                end
            end
            if (f == 3) r[m] = (cnt > 16);
            if (f == 1) begin
                int idx;
                idx = (m < 8 ? 0 : 2) + int'(cfg_oe_pick[m]);
                r[m] = m_term(80 + idx) ^ cfg_oe_inv[idx];
            end
        end
        if (f == 2) r = {13'd0, m_term(84) ^ cfg_set_inv, m_term(85) ^ cfg_rst_inv,
                         m_term(86) ^ cfg_clk_inv};
        return r;
    endfunction

    // Driver: inputs were changed right after an edge; expected items go to the queue
    task automatic apply(string req);
        @(posedge clk);
        #2;
        for (int f = 0; f < 5; f++) begin
            item_t it;
            it.req = req;
            it.field = f;
            it.exp = m_field(f);
            q.push_back(it);
        end
        @(posedge clk);
    endtask

    // Direct expectation pushed by a test for a hand-worked value
    task automatic expect_field(string req, int f, logic [15:0] v);
        item_t it;
        it.req = req;
        it.field = f;
        it.exp = v;
        q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, away from any driven change
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.field)
                0: act = mc_sum;
                1: act = mc_oe;
                2: act = {13'd0, blk_set, blk_rst, blk_clk};
                3: act = err_steer;
                default: act = err_share;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s field %0d: actual %h expected %h", it.req, it.field, act, it.exp);
            end
        end
    end

    task automatic clear_cfg();
        cfg_lit_en = '0; cfg_term_off = '0; cfg_sel = '0; cfg_oe_pick = '0;
        cfg_oe_inv = '0; cfg_set_inv = 1'b0; cfg_rst_inv = 1'b0; cfg_clk_inv = 1'b0;
    endtask

    task automatic hand_check(string req, int f, logic [15:0] v);
        @(posedge clk);
        #2;
        expect_field(req, f, v);
        @(posedge clk);
    endtask

    initial begin
        in_bits = '0;
        clear_cfg();
        // R8 R7 R3: cleared image: all terms empty and enabled, no steering
        hand_check("R3", 0, 16'h0000);
        hand_check("R7", 1, 16'hFFFF);
        hand_check("R8", 2, 16'h0007);

        // R1: term 0 = in[3] & ~in[5], steered to macrocell 0
        cfg_lit_en[0*NL+3] = 1'b1;
        cfg_lit_en[0*NL+NI+5] = 1'b1;
        cfg_sel[0*NG+0] = 1'b1;
        in_bits = 36'h8;
        hand_check("R1", 0, 16'h0001);
        in_bits = 36'h28;
        hand_check("R1", 0, 16'h0000);
        in_bits = 36'h0;
        apply("R1");

        // R2: empty mask vs disabled term
        clear_cfg();
        cfg_term_off[0] = 1'b1;
        cfg_sel[0*NG+0] = 1'b1;
        cfg_sel[1*NG+1] = 1'b1;
        hand_check("R2", 0, 16'h0002);

        // R3 R4: sharing of term 1 between macrocells 0 and 2
        clear_cfg();
        cfg_lit_en[0*NL+0] = 1'b1;
        cfg_lit_en[1*NL+1] = 1'b1;
        cfg_sel[0*NG+0] = 1'b1;
        cfg_sel[0*NG+1] = 1'b1;
        cfg_sel[2*NG+1] = 1'b1;
        in_bits = 36'h1;
        hand_check("R4", 0, 16'h0001);
        in_bits = 36'h2;
        hand_check("R4", 0, 16'h0005);
        in_bits = 36'h0;
        hand_check("R3", 0, 16'h0000);

        // R5: macrocell 0 reaches term 25 of group 1; macrocell 5 uses it legally
        clear_cfg();
        cfg_sel[0*NG+25] = 1'b1;
        cfg_sel[5*NG+25] = 1'b1;
        hand_check("R5", 0, 16'h0020);
        hand_check("R5", 4, 16'h0001);

        // R6: 16 in-group terms on macrocell 4 are legal, 17 are flagged
        clear_cfg();
        for (int t = 20; t < 36; t++) cfg_sel[4*NG+t] = 1'b1;
        hand_check("R6", 3, 16'h0000);
        cfg_sel[4*NG+36] = 1'b1;
        hand_check("R6", 3, 16'h0010);
        hand_check("R6", 0, 16'h0010);

        // R7: enable pairs per half with polarity and pick
        clear_cfg();
        cfg_lit_en[80*NL+0] = 1'b1;
        cfg_lit_en[81*NL+NI+0] = 1'b1;
        cfg_oe_inv[2] = 1'b1;
        cfg_term_off[83] = 1'b1;
        cfg_oe_pick[3] = 1'b1;
        cfg_oe_pick[12] = 1'b1;
        in_bits = 36'h1;
        hand_check("R7", 1, 16'h00F7);
        cfg_oe_inv[3] = 1'b1;
        in_bits = 36'h0;
        hand_check("R7", 1, 16'h1008);
        apply("R7");

        // R8: set follows in[2], reset disabled but inverted, clock inverted in[2]
        clear_cfg();
        cfg_lit_en[84*NL+2] = 1'b1;
        cfg_term_off[85] = 1'b1;
        cfg_rst_inv = 1'b1;
        cfg_lit_en[86*NL+2] = 1'b1;
        cfg_clk_inv = 1'b1;
        in_bits = 36'h4;
        hand_check("R8", 2, 16'h0006);
        in_bits = 36'h0;
        hand_check("R8", 2, 16'h0003);

        // R9: input changes between edges; outputs must follow before the next edge
        clear_cfg();
        cfg_lit_en[40*NL+NI+35] = 1'b1;
        cfg_sel[9*NG+40] = 1'b1;
        @(posedge clk);
        #4 in_bits = 36'h8_0000_0000;
        #2 expect_field("R9", 0, 16'h0000);
        @(negedge clk);
        #3 in_bits = 36'h0;
        #2 expect_field("R9", 0, 16'h0200);
        @(negedge clk);
        apply("R9");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule